// File: doc/BRIEF.md
# Relative Branch Condition Unit

This unit decides whether a two-byte relative branch instruction is taken and produces the program counter that follows it. It receives the opcode byte, the four arithmetic condition flags (negative, zero, overflow, carry), the address of the branch instruction and the signed 8-bit displacement that the instruction carries.

The branch group covers the sixteen opcodes 0x20 to 0x2F. They form eight pairs. In each pair the even opcode branches when a base condition is false, and the odd opcode branches when it is true. Any opcode outside the group is not taken, and the unit then returns the sequential address. The next PC leaves through a result register that the `REG_OUT` parameter can remove. With the default setting the result appears one clock after the inputs.

Top module: `brc_unit`

## Requirements
- R1: Opcode 0x20 is always taken, whatever the flags. Opcode 0x21 is never taken.
- R2: Opcode 0x24 is taken when carry is 0. Opcode 0x25 is taken when carry is 1.
- R3: Opcode 0x26 is taken when zero is 0. Opcode 0x27 is taken when zero is 1.
- R4: Opcode 0x22 is taken when (carry OR zero) is 0. Opcode 0x23 is taken when it is 1.
- R5: Opcode 0x2C is taken when (negative XOR overflow) is 0. Opcode 0x2D is taken when it is 1.
- R6: Opcode 0x2E is taken when (zero OR (negative XOR overflow)) is 0. Opcode 0x2F is taken when it is 1.
- R7: Opcodes 0x28 and 0x29 are taken when overflow is 0 and 1 respectively. Opcodes 0x2A and 0x2B are taken when negative is 0 and 1 respectively.
- R8: A taken branch gives next PC = instruction address + 2 + the displacement read as two's complement (0x80 is -128, 0x7F is +127). The sum wraps modulo 2^16.
- R9: A branch that is not taken, and every opcode whose upper nibble is not 0x2, gives taken_o = 0 and next PC = instruction address + 2, modulo 2^16.
- R10: With REG_OUT = 1, the result of inputs applied before a rising clock edge appears on the outputs after that edge. While rst_ni is low, taken_o is 0 and next_pc_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the result register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 8 | Opcode byte of the instruction |
| neg_i | input | 1 | Negative flag |
| zero_i | input | 1 | Zero flag |
| ovf_i | input | 1 | Overflow flag |
| carry_i | input | 1 | Carry flag |
| pc_i | input | 16 | Address of the branch instruction |
| disp_i | input | 8 | Signed displacement byte |
| taken_o | output | 1 | The branch is taken |
| next_pc_o | output | 16 | Address of the next instruction |

## Verification
The hardest cases to reach are those where the signed conditions of R5 and R6 disagree with the unsigned ones, and those where the target addition carries across the top of the address space. The stimulus applies every branch opcode against all sixteen flag combinations. Each pass rotates the displacement and address, so both conditions resolve both ways. Directed vectors then place the instruction at 0xFFFE, and near 0x0000 with displacement 0x80, to force the wrap in both directions. A set of opcodes outside the group checks that they always fall through.

// File: rtl/brc_pkg.sv
package brc_pkg;
  // base condition selected by opcode[3:1]; opcode[0] = 1 branches when it holds
  typedef enum logic [2:0] {
    SEL_NEVER  = 3'd0,
    SEL_LS     = 3'd1,
    SEL_CARRY  = 3'd2,
    SEL_ZERO   = 3'd3,
    SEL_OVF    = 3'd4,
    SEL_NEG    = 3'd5,
    SEL_LT     = 3'd6,
    SEL_LE     = 3'd7
  } cond_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] opcode_i,
  input  logic            in_group_i,
  input  flags_t          flags_i,
  output logic            taken_o
);
  cond_sel_e sel;
  logic      base;

  assign sel = cond_sel_e'(opcode_i[3:1]);

  always_comb begin
    unique case (sel)
      SEL_NEVER: base = 1'b0;
      SEL_LS:    base = flags_i.c | flags_i.z;
      SEL_CARRY: base = flags_i.c;
      SEL_ZERO:  base = flags_i.z;
      SEL_OVF:   base = flags_i.v;
      SEL_NEG:   base = flags_i.n;
      SEL_LT:    base = flags_i.n ^ flags_i.v;
      SEL_LE:    base = flags_i.z | (flags_i.n ^ flags_i.v);
      default:   base = 1'b0;
    endcase
  end

  // even opcode branches on the negated base condition
  assign taken_o = in_group_i & (base ^ ~opcode_i[0]);
endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
  parameter int ADDR_W    = 16,
  parameter int DISP_W    = 8,
  parameter int INSTR_LEN = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] seq_pc_o,
  output logic [ADDR_W-1:0] tgt_pc_o
);
  localparam int EXT_W = ADDR_W - DISP_W;
  localparam logic [ADDR_W-1:0] LEN = ADDR_W'(INSTR_LEN);

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign seq_pc_o = pc_i + LEN;
  assign tgt_pc_o = seq_pc_o + disp_ext;
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int  ADDR_W  = 16,
  parameter int  DISP_W  = 8,
  parameter int  OP_W    = 8,
  parameter logic [OP_W-5:0] BR_GROUP = 'h2,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic              neg_i,
  input  logic              zero_i,
  input  logic              ovf_i,
  input  logic              carry_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  flags_t            flags;
  logic              in_group;
  logic              taken_d;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] tgt_pc;
  logic [ADDR_W-1:0] next_pc_d;

  assign flags    = '{n: neg_i, z: zero_i, v: ovf_i, c: carry_i};
  assign in_group = (opcode_i[OP_W-1:4] == BR_GROUP);

  brc_cond_eval #(.OP_W(OP_W)) u_cond (
    .opcode_i   (opcode_i),
    .in_group_i (in_group),
    .flags_i    (flags),
    .taken_o    (taken_d)
  );

  brc_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .INSTR_LEN(2)) u_tgt (
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .seq_pc_o (seq_pc),
    .tgt_pc_o (tgt_pc)
  );

  assign next_pc_d = taken_d ? tgt_pc : seq_pc;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          taken_o   <= 1'b0;
          next_pc_o <= '0;
        end else begin
          taken_o   <= taken_d;
          next_pc_o <= next_pc_d;
        end
      end

      assert_always_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opcode_i == OP_W'('h20)) |=> taken_o);
      assert_never_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opcode_i == OP_W'('h21)) |=> !taken_o);
      assert_outside_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opcode_i[OP_W-1:4] != BR_GROUP) |=>
          (!taken_o && next_pc_o == $past(pc_i) + ADDR_W'(2)));
      assert_fallthru_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (taken_o || next_pc_o == $past(pc_i) + ADDR_W'(2)));
      assert_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (!taken_o || next_pc_o == $past(pc_i) + ADDR_W'(2)
                  + {{EXT_W{$past(disp_i[DISP_W-1])}}, $past(disp_i)}));
      assert_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opcode_i == OP_W'('h24) && carry_i) |=> !taken_o);
    end else begin : g_comb
      assign taken_o   = taken_d;
      assign next_pc_o = next_pc_d;
    end
  endgenerate
endmodule

// File: tb/brc_unit_tb.sv
module brc_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic        neg_i = 1'b0, zero_i = 1'b0, ovf_i = 1'b0, carry_i = 1'b0;
  logic [15:0] pc_i = 16'h0;
  logic [7:0]  disp_i = 8'h0;
  logic        taken_o;
  logic [15:0] next_pc_o;

  int total = 0;
  int bad = 0;
  bit drv_done = 1'b0;

  typedef struct {
    logic        taken;
    logic [15:0] pc;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk_i = ~clk_i;

  brc_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i),
    .neg_i(neg_i), .zero_i(zero_i), .ovf_i(ovf_i), .carry_i(carry_i),
    .pc_i(pc_i), .disp_i(disp_i), .taken_o(taken_o), .next_pc_o(next_pc_o)
  );

  function automatic logic model_take(input logic [7:0] op, input logic n, z, v, c);
    case (op)
      8'h20: return 1'b1;
      8'h21: return 1'b0;
      8'h22: return (c | z) == 1'b0;
      8'h23: return (c | z) == 1'b1;
      8'h24: return c == 1'b0;
      8'h25: return c == 1'b1;
      8'h26: return z == 1'b0;
      8'h27: return z == 1'b1;
      8'h28: return v == 1'b0;
      8'h29: return v == 1'b1;
      8'h2A: return n == 1'b0;
      8'h2B: return n == 1'b1;
      8'h2C: return (n ^ v) == 1'b0;
      8'h2D: return (n ^ v) == 1'b1;
      8'h2E: return (z | (n ^ v)) == 1'b0;
      8'h2F: return (z | (n ^ v)) == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h20, 8'h21: return "R1";
      8'h24, 8'h25: return "R2";
      8'h26, 8'h27: return "R3";
      8'h22, 8'h23: return "R4";
      8'h2C, 8'h2D: return "R5";
      8'h2E, 8'h2F: return "R6";
      8'h28, 8'h29, 8'h2A, 8'h2B: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(input logic [7:0] op, input logic [3:0] f,
                       input logic [15:0] pc, input logic [7:0] d, input string tag);
    exp_t e;
    logic tk;
    @(negedge clk_i);
    opcode_i = op; {neg_i, zero_i, ovf_i, carry_i} = f; pc_i = pc; disp_i = d;
    tk = model_take(op, f[3], f[2], f[1], f[0]);
    e.taken = tk;
    e.pc = tk ? (pc + 16'd2 + {{8{d[7]}}, d}) : (pc + 16'd2);
    e.req = (tag != "") ? tag : (tk ? {req_of(op), "/R8"} : {req_of(op), "/R9"});
    sb_q.push_back(e);
  endtask

  // monitor: result of the previous negedge drive is visible after this posedge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (rst_ni && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (taken_o !== e.taken || next_pc_o !== e.pc) begin
          bad++;
          $display("FAIL %s (R10 latency): taken=%0b pc=%h expected taken=%0b pc=%h",
                   e.req, taken_o, next_pc_o, e.taken, e.pc);
        end
      end
    end
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired (R10): actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    opcode_i = 8'h20; pc_i = 16'h1234; disp_i = 8'h10;
    repeat (3) @(posedge clk_i);
    #2;
    total++;
    if (taken_o !== 1'b0 || next_pc_o !== 16'h0) begin
      bad++;
      $display("FAIL R10 reset: taken=%0b pc=%h expected taken=0 pc=0000", taken_o, next_pc_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // every branch opcode against every flag combination
    for (int op = 8'h20; op <= 8'h2F; op++) begin
      for (int f = 0; f < 16; f++) begin
        drive(8'(op), 4'(f), 16'(16'h4000 + op * 37 + f * 5), 8'(f * 17 + op), "");
      end
    end

    // R8 wrap and displacement extremes
    drive(8'h20, 4'h0, 16'hFFFE, 8'h05, "R8 wrap up");
    drive(8'h20, 4'h0, 16'h0010, 8'h80, "R8 disp -128 wrap down");
    drive(8'h20, 4'h0, 16'h8000, 8'h7F, "R8 disp +127");
    drive(8'h20, 4'h0, 16'h8000, 8'hFE, "R8 self loop");
    drive(8'h21, 4'hF, 16'hFFFF, 8'h40, "R1 never wrap R9");
    drive(8'h2F, 4'hF, 16'h0000, 8'h80, "R6 taken wrap R8");

    // R9 opcodes outside the group
    for (int k = 0; k < 12; k++) begin
      logic [7:0] op;
      op = 8'(k * 23 + 3);
      if (op[7:4] == 4'h2) op = op ^ 8'h40;
      drive(op, 4'(k), 16'(16'hFFF0 + k), 8'h80, "R9 outside group");
    end
    drive(8'h30, 4'h0, 16'h1000, 8'h10, "R9 just above group");
    drive(8'h1F, 4'h0, 16'h1000, 8'h10, "R9 just below group");

    drv_done = 1'b1;
    while (sb_q.size() > 0) @(posedge clk_i);
    repeat (2) @(posedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule